// File: doc/BRIEF.md
# DMA Global Interrupt and Doorbell Hub

This block is the shared control and status section of a multi-channel DMA engine. It sits behind a simple 32-bit register bus and owns four global registers. A control word carries the engine enable, a fast-mode option and two sticky error flags. A pending word holds one interrupt bit per channel. A doorbell word, written with ones, starts descriptor fetches. A mask word records which channels may be programmed. Every bus access below the global window is steered to the addressed channel's register window, and the channel's read data is returned on the shared bus.

Each channel appears only as three event inputs (transfer done, halt, address error), one fetch-start output and its slice of the channel read-data bus. Done events latch into the pending word. Halt and address-error events from any channel latch into the matching global flags. The pending word and the flags are cleared by software writing zeros, and a channel event that lands in the same cycle as a clear always survives. A single registered interrupt line reports that any pending bit is set while the engine is enabled.

Top module: `dma_irq_hub`

## Requirements
- R1: After synchronous reset the control, pending and mask registers read zero, the interrupt line is low, no fetch-start pulse is raised and the read-data bus is zero.
- R2: The control register sits at offset 0x1000. Bit 0 is the engine enable and bit 31 the fast-mode option; both are written directly and read back. Bit 31 also drives the fast_mode output. Bit 1 and bits 4 to 30 read as zero.
- R3: Control bit 3 is the sticky halt flag and bit 2 the sticky address-error flag. A halt event on any channel sets bit 3 and an address-error event on any channel sets bit 2. A control write with the bit at zero clears the flag, and with the bit at one leaves it unchanged.
- R4: The pending register at offset 0x1004 holds bit n for channel n. A done event on channel n sets bit n. A write clears every bit written as zero and keeps every bit written as one.
- R5: When a channel event and a clearing write reach the same pending bit or flag in one cycle, the bit ends set.
- R6: Writing the doorbell register at offset 0x100C with bit n at one raises fetch_start[n] for exactly the one cycle after the write. Bits written as zero raise nothing, and a read of the doorbell returns zero.
- R7: A doorbell write while the enable bit is zero raises no fetch_start pulse.
- R8: irq is high exactly when the enable bit is one and at least one pending bit is set, and it changes on the same clock edge as the registers it depends on.
- R9: The programmable-channel mask at offset 0x101C is a read-write register with one bit per channel. It changes only when written.
- R10: Reads of any other offset at or above 0x1000, and of offsets between the last channel window and 0x1000, return zero. Writes to these offsets change no register.
- R11: An access at offset below NUM_CH×0x20 is forwarded to channel n = offset/0x20. In the access cycle ch_sel has only bit n set, ch_offset carries the offset bits 4..0, and ch_wr or ch_rd follows the strobe. For a read, channel n's 32-bit word appears on bus_rdata in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd, zero otherwise |
| ch_done | input | NUM_CH | Per-channel transfer-done event |
| ch_halt | input | NUM_CH | Per-channel halt event |
| ch_addr_err | input | NUM_CH | Per-channel address-error event |
| ch_rdata_flat | input | NUM_CH×32 | Read words from all channel windows, channel n at bits 32n+31..32n |
| ch_sel | output | NUM_CH | One-hot select of the addressed channel window |
| ch_wr | output | 1 | Forwarded write strobe |
| ch_rd | output | 1 | Forwarded read strobe |
| ch_offset | output | 5 | Offset inside the channel window |
| ch_wdata | output | 32 | Forwarded write data |
| fetch_start | output | NUM_CH | One-cycle descriptor-fetch start per channel |
| irq | output | 1 | Combined interrupt line |
| fast_mode | output | 1 | Fast-mode option bit |

## Verification
Directed sequences isolate the awkward timing cases. These are a clearing write that collides with a done or error event, a doorbell rung while the engine is disabled, an interrupt masked by the enable while bits stay pending, and reads that fall into the gap between the channel windows and the global window. Channel-window reads at the first and last channel tell a correct index decode from an off-by-one or truncated one. A long seeded random run then interleaves writes with mixed keep/clear patterns, doorbell writes, mask updates, unmapped accesses and sparse random events on all three event buses. Each cycle is compared against a bench-side register model, so a lost event, a misplaced field or a pulse that lasts two cycles shows up as a mismatch in the cycle where it occurs.

// File: rtl/dih_pkg.sv
package dih_pkg;
  localparam int BUS_W         = 32;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_AERR_BIT = 2;
  localparam int CTRL_HALT_BIT = 3;
  localparam int CTRL_FAST_BIT = 31;

  // Register offsets inside the global window
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_PEND = 'h04;
  localparam int OFS_DOOR = 'h0C;
  localparam int OFS_MASK = 'h1C;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_PEND,
    TGT_DOOR,
    TGT_MASK,
    TGT_CHAN
  } tgt_e;
endpackage

// File: rtl/dih_decode.sv
module dih_decode
  import dih_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 13,
  parameter int CH_WIN   = 32,
  parameter int GLB_BASE = 'h1000,
  localparam int OFF_W   = $clog2(CH_WIN),
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  ch_idx,
  output logic [NUM_CH-1:0] ch_sel_oh
);
  localparam int CH_SPAN = NUM_CH * CH_WIN;
  localparam logic [ADDR_W-1:0] A_SPAN = ADDR_W'(CH_SPAN);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(GLB_BASE + OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(GLB_BASE + OFS_PEND);
  localparam logic [ADDR_W-1:0] A_DOOR = ADDR_W'(GLB_BASE + OFS_DOOR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(GLB_BASE + OFS_MASK);

  always_comb begin
    tgt = TGT_NONE;
    if (addr < A_SPAN)       tgt = TGT_CHAN;
    else if (addr == A_CTRL) tgt = TGT_CTRL;
    else if (addr == A_PEND) tgt = TGT_PEND;
    else if (addr == A_DOOR) tgt = TGT_DOOR;
    else if (addr == A_MASK) tgt = TGT_MASK;
  end

  assign ch_idx = addr[OFF_W +: IDX_W];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel_oh[g] = (tgt == TGT_CHAN) && (ch_idx == IDX_W'(g));
  end

  // R11: at most one channel window is selected
  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_sel_oh));
  // R11: a selection only ever comes with a channel-range address
  p_sel_in_span_r11: assert property (@(posedge clk) disable iff (rst)
    (|ch_sel_oh) |-> (addr < A_SPAN));
endmodule

// File: rtl/dih_events.sv
module dih_events #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_wr,
  input  logic [NUM_CH-1:0] pend_keep,
  input  logic              ctrl_wr,
  input  logic              keep_halt,
  input  logic              keep_aerr,
  input  logic              en_d,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic [NUM_CH-1:0] ch_halt,
  input  logic [NUM_CH-1:0] ch_aerr,
  output logic [NUM_CH-1:0] pend_q,
  output logic              halt_q,
  output logic              aerr_q,
  output logic              irq_q
);
  logic [NUM_CH-1:0] pend_d;
  logic              halt_d, aerr_d;

  // Events are ORed in after the clear, so an event always wins.
  always_comb begin
    pend_d = (pend_wr ? (pend_q & pend_keep) : pend_q) | ch_done;
    halt_d = (ctrl_wr ? (halt_q & keep_halt) : halt_q) | (|ch_halt);
    aerr_d = (ctrl_wr ? (aerr_q & keep_aerr) : aerr_q) | (|ch_aerr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      halt_q <= 1'b0;
      aerr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      halt_q <= halt_d;
      aerr_q <= aerr_d;
      irq_q  <= en_d & (|pend_d);
    end
  end

  // R4: a pending bit only rises after a done event on its channel
  p_pend_rise_r4: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(ch_done)) == '0));
  // R4: bits written as zero are gone unless an event hit them
  p_pend_clear_r4: assert property (@(posedge clk) disable iff (rst)
    pend_wr |=> ((pend_q & ~$past(pend_keep) & ~$past(ch_done)) == '0));
  // R5: done events survive a colliding clear
  p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_wr && (|ch_done)) |=> ((pend_q & $past(ch_done)) == $past(ch_done)));
  // R3: any halt sets the global halt flag
  p_halt_set_r3: assert property (@(posedge clk) disable iff (rst)
    (|ch_halt) |=> halt_q);
  // R3: any address error sets the global flag
  p_aerr_set_r3: assert property (@(posedge clk) disable iff (rst)
    (|ch_aerr) |=> aerr_q);
  // R3: flags never drop without a control write
  p_halt_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !ctrl_wr) |=> halt_q);
  // R8: the interrupt needs a pending bit
  p_irq_pend_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|pend_q));
endmodule

// File: rtl/dih_doorbell.sv
module dih_doorbell #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              door_wr,
  input  logic              en_q,
  input  logic [NUM_CH-1:0] ring,
  output logic [NUM_CH-1:0] pulse_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bell
    always_ff @(posedge clk) begin
      if (rst) pulse_q[g] <= 1'b0;
      else     pulse_q[g] <= door_wr & en_q & ring[g];
    end
  end

  // R7: no pulse unless the engine was enabled at the doorbell write
  p_pulse_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (|pulse_q) |-> $past(en_q && door_wr));
  // R6: without a doorbell write the next cycle is quiet
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    !door_wr |=> (pulse_q == '0));
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
  import dih_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 13,
  parameter int CH_WIN   = 32,
  parameter int GLB_BASE = 'h1000,
  localparam int OFF_W   = $clog2(CH_WIN),
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]       ch_done,
  input  logic [NUM_CH-1:0]       ch_halt,
  input  logic [NUM_CH-1:0]       ch_addr_err,
  input  logic [NUM_CH*BUS_W-1:0] ch_rdata_flat,
  output logic [NUM_CH-1:0]       ch_sel,
  output logic                    ch_wr,
  output logic                    ch_rd,
  output logic [OFF_W-1:0]        ch_offset,
  output logic [BUS_W-1:0]        ch_wdata,
  output logic [NUM_CH-1:0]       fetch_start,
  output logic                    irq,
  output logic                    fast_mode
);
  tgt_e              tgt;
  logic [IDX_W-1:0]  ch_idx;
  logic              en_q, en_d, fast_q;
  logic [NUM_CH-1:0] mask_q, pend_q;
  logic              halt_q, aerr_q;
  logic              wr_ctrl, wr_pend, wr_door, wr_mask;
  logic [BUS_W-1:0]  rd_val, ch_word, ctrl_word;
  logic              unused_wbits;

  dih_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_WIN(CH_WIN), .GLB_BASE(GLB_BASE)
  ) u_decode (
    .clk(clk), .rst(rst), .addr(bus_addr),
    .tgt(tgt), .ch_idx(ch_idx), .ch_sel_oh(ch_sel)
  );

  assign wr_ctrl = bus_wr && (tgt == TGT_CTRL);
  assign wr_pend = bus_wr && (tgt == TGT_PEND);
  assign wr_door = bus_wr && (tgt == TGT_DOOR);
  assign wr_mask = bus_wr && (tgt == TGT_MASK);
  assign en_d    = wr_ctrl ? bus_wdata[CTRL_EN_BIT] : en_q;

  // Channel forwarding
  assign ch_wr     = bus_wr && (tgt == TGT_CHAN);
  assign ch_rd     = bus_rd && (tgt == TGT_CHAN);
  assign ch_offset = bus_addr[OFF_W-1:0];
  assign ch_wdata  = bus_wdata;
  assign ch_word   = ch_rdata_flat[int'(ch_idx)*BUS_W +: BUS_W];

  dih_events #(.NUM_CH(NUM_CH)) u_events (
    .clk(clk), .rst(rst),
    .pend_wr(wr_pend), .pend_keep(bus_wdata[NUM_CH-1:0]),
    .ctrl_wr(wr_ctrl),
    .keep_halt(bus_wdata[CTRL_HALT_BIT]), .keep_aerr(bus_wdata[CTRL_AERR_BIT]),
    .en_d(en_d),
    .ch_done(ch_done), .ch_halt(ch_halt), .ch_aerr(ch_addr_err),
    .pend_q(pend_q), .halt_q(halt_q), .aerr_q(aerr_q), .irq_q(irq)
  );

  dih_doorbell #(.NUM_CH(NUM_CH)) u_doorbell (
    .clk(clk), .rst(rst),
    .door_wr(wr_door), .en_q(en_q), .ring(bus_wdata[NUM_CH-1:0]),
    .pulse_q(fetch_start)
  );

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_EN_BIT]   = en_q;
    ctrl_word[CTRL_AERR_BIT] = aerr_q;
    ctrl_word[CTRL_HALT_BIT] = halt_q;
    ctrl_word[CTRL_FAST_BIT] = fast_q;
  end

  always_comb begin
    case (tgt)
      TGT_CTRL: rd_val = ctrl_word;
      TGT_PEND: rd_val = BUS_W'(pend_q);
      TGT_MASK: rd_val = BUS_W'(mask_q);
      TGT_CHAN: rd_val = ch_word;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      fast_q    <= 1'b0;
      mask_q    <= '0;
      bus_rdata <= '0;
    end else begin
      en_q      <= en_d;
      if (wr_ctrl) fast_q <= bus_wdata[CTRL_FAST_BIT];
      if (wr_mask) mask_q <= bus_wdata[NUM_CH-1:0];
      bus_rdata <= bus_rd ? rd_val : '0;
    end
  end

  assign fast_mode    = fast_q;
  assign unused_wbits = ^bus_wdata;

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (tgt == TGT_NONE)) |=> (bus_rdata == '0));
  // R9: the mask only moves when written
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q));
  // R8: the interrupt is masked by the enable
  p_irq_enable_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> en_q);
  // R1: read data is zero when no read was issued
  p_rdata_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/dma_irq_hub_test.sv
`timescale 1ns/1ps
module dma_irq_hub_test;
  localparam int NCH = 32;
  localparam int AW  = 13;
  localparam logic [AW-1:0] A_CTRL = 13'h1000;
  localparam logic [AW-1:0] A_PEND = 13'h1004;
  localparam logic [AW-1:0] A_DOOR = 13'h100C;
  localparam logic [AW-1:0] A_MASK = 13'h101C;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  ch_done = '0, ch_halt = '0, ch_addr_err = '0;
  logic [NCH*32-1:0] ch_rdata_flat;
  logic [NCH-1:0]  ch_sel, fetch_start;
  logic            ch_wr, ch_rd, irq, fast_mode;
  logic [4:0]      ch_offset;
  logic [31:0]     ch_wdata;

  int n_chk = 0;
  int n_bad = 0;

  logic        m_en = 0, m_fast = 0, m_halt = 0, m_aerr = 0;
  logic [31:0] m_pend = '0, m_mask = '0;

  always #10 clk = ~clk;

  dma_irq_hub uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_done(ch_done),
    .ch_halt(ch_halt), .ch_addr_err(ch_addr_err), .ch_rdata_flat(ch_rdata_flat),
    .ch_sel(ch_sel), .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_offset(ch_offset),
    .ch_wdata(ch_wdata), .fetch_start(fetch_start), .irq(irq), .fast_mode(fast_mode)
  );

  function automatic logic [31:0] chan_word(int n);
    return 32'hCA00_005A | (32'(n) << 8);
  endfunction

  always_comb
    for (int i = 0; i < NCH; i++) ch_rdata_flat[i*32 +: 32] = chan_word(i);

  function automatic logic [31:0] ctrl_word();
    return {m_fast, 27'b0, m_halt, m_aerr, 1'b0, m_en};
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    if (a < 13'h400)  return chan_word(int'(a >> 5));
    if (a == A_CTRL)  return ctrl_word();
    if (a == A_PEND)  return m_pend;
    if (a == A_MASK)  return m_mask;
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle plus events; starts and ends at a falling edge.
  task automatic step(string req, logic [AW-1:0] a, logic wr, logic rd,
                      logic [31:0] wd, logic [31:0] dn, logic [31:0] hl,
                      logic [31:0] ae);
    logic [31:0] x_rd, x_db;
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    ch_done = dn; ch_halt = hl; ch_addr_err = ae;
    x_rd = rd ? exp_read(a) : 32'h0;
    x_db = (wr && a == A_DOOR && m_en) ? wd : 32'h0;
    if (wr && a == A_CTRL) begin
      m_en = wd[0]; m_fast = wd[31];
      m_halt = m_halt & wd[3]; m_aerr = m_aerr & wd[2];
    end
    if (wr && a == A_PEND) m_pend = m_pend & wd;
    if (wr && a == A_MASK) m_mask = wd;
    m_pend = m_pend | dn;
    m_halt = m_halt | (|hl);
    m_aerr = m_aerr | (|ae);
    @(posedge clk);
    @(negedge clk);
    if (rd) chk({req, " rdata"}, bus_rdata, x_rd);
    chk({req, " fetch_start"}, fetch_start, x_db);
    chk({req, " irq"}, {31'b0, irq}, {31'b0, m_en & (|m_pend)});
    bus_wr = 0; bus_rd = 0; ch_done = '0; ch_halt = '0; ch_addr_err = '0;
  endtask

  task automatic wr(string req, logic [AW-1:0] a, logic [31:0] d);
    step(req, a, 1, 0, d, 0, 0, 0);
  endtask
  task automatic rd(string req, logic [AW-1:0] a);
    step(req, a, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fetch_start", fetch_start, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd("R1", A_CTRL); rd("R1", A_PEND); rd("R1", A_MASK);

    // R2: enable and fast mode
    wr("R2", A_CTRL, 32'h8000_0001);
    rd("R2", A_CTRL);
    chk("R2 fast_mode", {31'b0, fast_mode}, 1);
    wr("R2", A_CTRL, 32'hFFFF_FFF1);
    rd("R2", A_CTRL);

    // R11: forwarding, checked in the access cycle
    bus_addr = 13'h0A4; bus_wr = 1; bus_wdata = 32'h1234_5678;
    #1;
    chk("R11 ch_sel", ch_sel, 32'h0000_0020);
    chk("R11 ch_offset", {27'b0, ch_offset}, 4);
    chk("R11 ch_wr", {31'b0, ch_wr}, 1);
    chk("R11 ch_wdata", ch_wdata, 32'h1234_5678);
    bus_wr = 0; bus_rd = 1; bus_addr = 13'h3FC;
    #1;
    chk("R11 ch_sel last", ch_sel, 32'h8000_0000);
    chk("R11 ch_rd", {31'b0, ch_rd}, 1);
    bus_rd = 0;
    @(negedge clk);
    rd("R11", 13'h3E0); rd("R11", 13'h000); rd("R11", 13'h1F8);

    // R6: doorbell pulses, then quiet
    wr("R6", A_DOOR, 32'h0000_0011);
    rd("R6 quiet", A_DOOR);
    wr("R6", A_DOOR, 32'h8000_0000);
    // R7: suppressed while disabled
    wr("R7", A_CTRL, 32'h0);
    wr("R7", A_DOOR, 32'hFFFF_FFFF);
    wr("R7", A_CTRL, 32'h1);

    // R4: done sets, write-zero clears
    step("R4", A_CTRL, 0, 0, 0, 32'h0000_0088, 0, 0);
    rd("R4", A_PEND);
    wr("R4", A_PEND, 32'hFFFF_FF7F);
    rd("R4", A_PEND);
    // R8: enable masks irq while bits stay pending
    wr("R8", A_CTRL, 32'h0);
    rd("R8", A_PEND);
    wr("R8", A_CTRL, 32'h1);
    // R5: event beats clear
    step("R5", A_PEND, 1, 0, 32'h0, 32'h0000_0208, 0, 0);
    rd("R5", A_PEND);
    wr("R8", A_PEND, 32'h0);

    // R3: sticky flags
    step("R3", A_MASK, 0, 0, 0, 0, 32'h0000_1000, 0);
    rd("R3", A_CTRL);
    wr("R3", A_CTRL, 32'h0000_0009);
    rd("R3", A_CTRL);
    wr("R3", A_CTRL, 32'h0000_0001);
    rd("R3", A_CTRL);
    step("R5 flag", A_CTRL, 1, 0, 32'h1, 0, 0, 32'h0040_0000);
    rd("R5", A_CTRL);
    wr("R3", A_CTRL, 32'h1);
    rd("R3", A_CTRL);

    // R9: mask
    wr("R9", A_MASK, 32'hDEAD_BEEF);
    rd("R9", A_MASK);
    // R10: unmapped
    wr("R10", 13'h1008, 32'hFFFF_FFFF);
    wr("R10", 13'h1FFC, 32'h0);
    wr("R10", 13'h0800, 32'h0);
    rd("R10", 13'h1008); rd("R10", 13'h1010); rd("R10", 13'h0800);
    rd("R10", A_CTRL); rd("R10", A_PEND); rd("R10", A_MASK);

    // Random mix against the model (R3 R4 R5 R6 R8 R9 R10 R11)
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [AW-1:0] a;
      logic [31:0] d, dn, hl, ae;
      op = $urandom_range(0, 9);
      d  = $urandom;
      dn = $urandom & $urandom & $urandom;
      hl = ($urandom_range(0, 15) == 0) ? (32'h1 << $urandom_range(0, 31)) : 0;
      ae = ($urandom_range(0, 15) == 0) ? (32'h1 << $urandom_range(0, 31)) : 0;
      case (op)
        0: begin a = A_CTRL; if ($urandom_range(0, 3) != 0) d[0] = 1; end
        1: a = A_PEND;
        2: a = A_DOOR;
        3: a = A_MASK;
        4: a = AW'(13'h1000 + 4 * $urandom_range(0, 15));
        5: a = AW'($urandom_range(0, 13'h3FF));
        6: a = AW'($urandom_range(13'h400, 13'h1FFF));
        default: a = ($urandom_range(0, 1) == 1) ? A_PEND : A_CTRL;
      endcase
      if (op == 2 || $urandom_range(0, 1) == 1)
        step("R4/R6 random write", a, 1, 0, d, dn, hl, ae);
      else
        step("R8/R10 random read", a, 0, 1, d, dn, hl, ae);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule